// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block takes 64-bit command writes and turns each one into a write of one 32-bit word in the register space of another core. The command holds the target core number, a selector or a full word address, four keep bits and the new data word. Two command offsets are decoded. The "mail" offset aims at one of eight mailbox words above a fixed base. The "direct" offset carries its own 16-bit word address. When any keep bit is set, the block first reads the old word, keeps the marked bytes from it, fills the other bytes from the new data and writes the result back. When no keep bit is set, it writes the new data at once and makes no read.

Commands enter on a valid/ready channel. `cmd_ready` is high only while the block is idle, so at most one command is in flight. A command that is presented while the block is busy waits, with its fields held, until `cmd_ready` rises. The read request and the write request each go out on their own valid/ready channel. Once a request is raised, it keeps its fields until the target side takes it. The read data comes back as a one-cycle `rd_rsp_valid` pulse, which the block always accepts. Both requests carry the target core number as the requester identity. Every command ends with a one-cycle `rsp_valid` pulse. `rsp_err` marks a command whose target core does not exist.

Top module: `mbox_rmw_writer`

## Requirements
- R1: Only the low 12 bits of `cmd_addr` are decoded. A command acts only when `cmd_wide`=1 (a 64-bit access) and those bits equal `MAIL_OFS` (default 0x048) or `ANY_OFS` (default 0x158). Any other command is accepted and answered with `rsp_err`=0, and it makes no read and no write.
- R2: The target core is `cmd_data[25:16]`. A value of `NUM_CORES` (default 4) or more gets `rsp_err`=1, and no read or write is made.
- R3: For the mail offset, the word address is `MBOX_BASE` (default 0x1000) + 0x20 + 4*`cmd_data[4:2]`.
- R4: For the direct offset, the word address is `cmd_data[15:0]`.
- R5: Keep bit i is `cmd_data[27+i]`, for i from 0 to 3. When any keep bit is set, one read of the word address is made first. The written word then takes byte i from the old word where keep bit i is 1, and from `cmd_data[63:32]` where it is 0.
- R6: When `cmd_data[30:27]` is zero, no read is made and `cmd_data[63:32]` is written unchanged.
- R7: `rd_core` and `wr_core` carry the target core number from the command.
- R8: `busy` is high, and `cmd_ready` low, from the cycle after a command is accepted until the cycle in which `rsp_valid` pulses. `busy` drops in the cycle after that pulse. The pulse comes in the cycle after the write handshake, or in the cycle after acceptance when no access is made.
- R9: While `rd_valid` or `wr_valid` is high and its ready is low, the request stays raised and its address, core and data hold steady.
- R10: After reset the block is idle: `busy`, `rd_valid`, `wr_valid` and `rsp_valid` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken on this edge |
| cmd_addr | input | IN_ADDR_W | Command offset; low 12 bits decoded |
| cmd_wide | input | 1 | 1 = 64-bit access |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | Command in flight |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Unknown target core (valid with rsp_valid) |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | 16 | Read word address |
| rd_core | output | 10 | Requester identity for the read |
| rd_rsp_valid | input | 1 | Read data pulse, at least one cycle after the read handshake |
| rd_rsp_data | input | 32 | Old word |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write request taken |
| wr_addr | output | 16 | Write word address |
| wr_core | output | 10 | Requester identity for the write |
| wr_data | output | 32 | Word to write |

## Verification
Some rules are checked by assertions on every cycle:
- a request under back-pressure holds its fields;
- a read handshake is never followed at once by a write request;
- a write handshake is followed by a clean completion, and busy falls after it;
- an unknown core draws an error pulse;
- a write never names a core outside the legal range.

Other behaviour shows only in the bench's scenarios, which run against a memory model:
- the merged word for each keep pattern;
- the mail and direct addresses, and the core identity carried on each access;
- whether a read took place at all;
- that ignored offsets, narrow accesses and bad cores leave the target word untouched.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

  localparam int unsigned CMD_W      = 64;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NBYTES     = WORD_W / 8;
  localparam int unsigned WADDR_W    = 16;
  localparam int unsigned CORE_W     = 10;
  localparam int unsigned CORE_LSB   = 16;
  localparam int unsigned KEEP_LSB   = 27;
  localparam int unsigned DATA_LSB   = 32;
  localparam int unsigned SEL_LSB    = 2;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned OFS_W      = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_RESP
  } mbw_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_MAIL,
    OP_ANY
  } mbw_op_e;

  typedef struct packed {
    mbw_op_e             op;
    logic                core_ok;
    logic [WADDR_W-1:0]  waddr;
    logic [CORE_W-1:0]   core;
    logic [NBYTES-1:0]   keep;
    logic [WORD_W-1:0]   data;
  } mbw_cmd_t;

endpackage

// File: rtl/mbw_decode.sv
module mbw_decode
  import mbw_pkg::*;
#(
  parameter int unsigned          NUM_CORES = 4,
  parameter int unsigned          IN_ADDR_W = 16,
  parameter logic [OFS_W-1:0]     MAIL_OFS  = 12'h048,
  parameter logic [OFS_W-1:0]     ANY_OFS   = 12'h158,
  parameter logic [WADDR_W-1:0]   MBOX_BASE = 16'h1000
) (
  input  logic [IN_ADDR_W-1:0] addr,
  input  logic                 wide,
  input  logic [CMD_W-1:0]     cmd,
  output mbw_cmd_t             dec
);

  localparam logic [WADDR_W-1:0] MBOX_WORDS = MBOX_BASE + 16'h0020;

  logic [OFS_W-1:0]   ofs;
  logic [WADDR_W-1:0] mail_addr;

  assign ofs       = addr[OFS_W-1:0];
  assign mail_addr = MBOX_WORDS
                   + {{(WADDR_W-SEL_W-SEL_LSB){1'b0}}, cmd[SEL_LSB +: SEL_W], {SEL_LSB{1'b0}}};

  always_comb begin
    dec.op = OP_NONE;
    if (wide && ofs == MAIL_OFS) dec.op = OP_MAIL;
    else if (wide && ofs == ANY_OFS) dec.op = OP_ANY;
    dec.core    = cmd[CORE_LSB +: CORE_W];
    dec.core_ok = (32'(dec.core) < 32'(NUM_CORES));
    dec.waddr   = (dec.op == OP_MAIL) ? mail_addr : cmd[WADDR_W-1:0];
    dec.keep    = cmd[KEEP_LSB +: NBYTES];
    dec.data    = cmd[DATA_LSB +: WORD_W];
  end

endmodule

// File: rtl/mbw_merge.sv
module mbw_merge
  import mbw_pkg::*;
#(
  parameter int unsigned LANES = NBYTES
) (
  input  logic [LANES*8-1:0] old_word,
  input  logic [LANES*8-1:0] new_word,
  input  logic [LANES-1:0]   keep,
  output logic [LANES*8-1:0] merged
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*8 +: 8] = keep[i] ? old_word[i*8 +: 8] : new_word[i*8 +: 8];
  end

endmodule

// File: rtl/mbw_seq.sv
module mbw_seq
  import mbw_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  mbw_cmd_t            dec,
  output logic                busy,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic                rd_valid,
  input  logic                rd_ready,
  input  logic                rd_rsp_valid,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [WADDR_W-1:0]  req_addr,
  output logic [CORE_W-1:0]   req_core,
  output logic [WORD_W-1:0]   data_q,
  output logic [NBYTES-1:0]   keep_q,
  input  logic [WORD_W-1:0]   merged
);

  mbw_state_e state_q;
  logic       err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_q    <= 1'b0;
      req_addr <= '0;
      req_core <= '0;
      data_q   <= '0;
      keep_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          err_q <= 1'b0;
          if (dec.op == OP_NONE) begin
            state_q <= ST_RESP;
          end else if (!dec.core_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            req_addr <= dec.waddr;
            req_core <= dec.core;
            data_q   <= dec.data;
            keep_q   <= dec.keep;
            state_q  <= (dec.keep != '0) ? ST_RD_REQ : ST_WR_REQ;
          end
        end
        ST_RD_REQ:  if (rd_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rd_rsp_valid) begin
          data_q  <= merged;
          state_q <= ST_WR_REQ;
        end
        ST_WR_REQ:  if (wr_ready) state_q <= ST_RESP;
        ST_RESP:    state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rd_valid  = (state_q == ST_RD_REQ);
  assign wr_valid  = (state_q == ST_WR_REQ);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;

  // R9: a stalled request keeps its fields
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(req_addr) && $stable(req_core));
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(req_addr) && $stable(req_core) && $stable(data_q));
  // R5: the write waits for the read data
  a_r5_wait_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !wr_valid);
  // R8: completion follows the write handshake, then busy falls
  a_r8_resp_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> rsp_valid && !rsp_err);
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy && cmd_ready);
  // R7: write identity is a legal core
  a_r7_core_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> 32'(req_core) < 32'(NUM_CORES));

endmodule

// File: rtl/mbox_rmw_writer.sv
module mbox_rmw_writer
  import mbw_pkg::*;
#(
  parameter int unsigned        NUM_CORES = 4,
  parameter int unsigned        IN_ADDR_W = 16,
  parameter logic [11:0]        MAIL_OFS  = 12'h048,
  parameter logic [11:0]        ANY_OFS   = 12'h158,
  parameter logic [15:0]        MBOX_BASE = 16'h1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [IN_ADDR_W-1:0] cmd_addr,
  input  logic                 cmd_wide,
  input  logic [63:0]          cmd_data,
  output logic                 busy,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [15:0]          rd_addr,
  output logic [9:0]           rd_core,
  input  logic                 rd_rsp_valid,
  input  logic [31:0]          rd_rsp_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [15:0]          wr_addr,
  output logic [9:0]           wr_core,
  output logic [31:0]          wr_data
);

  mbw_cmd_t            dec;
  logic [WADDR_W-1:0]  req_addr;
  logic [CORE_W-1:0]   req_core;
  logic [WORD_W-1:0]   data_q;
  logic [NBYTES-1:0]   keep_q;
  logic [WORD_W-1:0]   merged;

  mbw_decode #(
    .NUM_CORES (NUM_CORES),
    .IN_ADDR_W (IN_ADDR_W),
    .MAIL_OFS  (MAIL_OFS),
    .ANY_OFS   (ANY_OFS),
    .MBOX_BASE (MBOX_BASE)
  ) u_decode (
    .addr (cmd_addr),
    .wide (cmd_wide),
    .cmd  (cmd_data),
    .dec  (dec)
  );

  mbw_merge #(.LANES(NBYTES)) u_merge (
    .old_word (rd_rsp_data),
    .new_word (data_q),
    .keep     (keep_q),
    .merged   (merged)
  );

  mbw_seq #(.NUM_CORES(NUM_CORES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .dec          (dec),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .req_addr     (req_addr),
    .req_core     (req_core),
    .data_q       (data_q),
    .keep_q       (keep_q),
    .merged       (merged)
  );

  assign rd_addr = req_addr;
  assign rd_core = req_core;
  assign wr_addr = req_addr;
  assign wr_core = req_core;
  assign wr_data = data_q;

  // R2: an acting command for a missing core ends in an error pulse
  a_r2_bad_core: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && dec.op != OP_NONE && !dec.core_ok |=> rsp_valid && rsp_err && !wr_valid && !rd_valid);
  // R1: an ignored command completes without error or access
  a_r1_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && dec.op == OP_NONE |=> rsp_valid && !rsp_err);

endmodule

// File: tb/mbox_rmw_writer_test.sv
module mbox_rmw_writer_test;

  typedef struct packed {
    logic [15:0] ofs;
    logic        wide;
    logic [63:0] cmd;
    logic [31:0] pre;
    logic [15:0] waddr;
    logic [31:0] word;
    logic        err;
    logic        rd;
    logic        wr;
    logic [9:0]  core;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0048, 1'b1, 64'h11223344_0002000C, 32'hDEADBEEF, 16'h102C, 32'h11223344, 1'b0, 1'b0, 1'b1, 10'd2},
    '{16'h0048, 1'b1, 64'hAABBCCDD_2801001C, 32'h12345678, 16'h103C, 32'hAA34CC78, 1'b0, 1'b1, 1'b1, 10'd1},
    '{16'h0158, 1'b1, 64'h55555555_78030210, 32'hCAFEF00D, 16'h0210, 32'hCAFEF00D, 1'b0, 1'b1, 1'b1, 10'd3},
    '{16'h0158, 1'b1, 64'h01020304_40000124, 32'hF0E0D0C0, 16'h0124, 32'hF0020304, 1'b0, 1'b1, 1'b1, 10'd0},
    '{16'h0048, 1'b1, 64'h77777777_00040000, 32'h0BADC0DE, 16'h1020, 32'h0BADC0DE, 1'b1, 1'b0, 1'b0, 10'd0},
    '{16'h0158, 1'b1, 64'h66666666_0BFF0040, 32'h13579BDF, 16'h0040, 32'h13579BDF, 1'b1, 1'b0, 1'b0, 10'd0},
    '{16'h0050, 1'b1, 64'h99999999_00010030, 32'h2468ACE0, 16'h0030, 32'h2468ACE0, 1'b0, 1'b0, 1'b0, 10'd0},
    '{16'h0048, 1'b0, 64'h44444444_00010000, 32'hFEEDFACE, 16'h1020, 32'hFEEDFACE, 1'b0, 1'b0, 1'b0, 10'd0},
    '{16'hF048, 1'b1, 64'h89ABCDEF_00000000, 32'h00000000, 16'h1020, 32'h89ABCDEF, 1'b0, 1'b0, 1'b1, 10'd0},
    '{16'h0158, 1'b1, 64'h11111111_1003FFFC, 32'h22222222, 16'hFFFC, 32'h11112211, 1'b0, 1'b1, 1'b1, 10'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_addr = '0;
  logic        cmd_wide = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        busy, rsp_valid, rsp_err;
  logic        rd_valid, rd_ready, wr_valid, wr_ready;
  logic [15:0] rd_addr, wr_addr;
  logic [9:0]  rd_core, wr_core;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic [31:0] wr_data;

  mbox_rmw_writer uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_wide(cmd_wide), .cmd_data(cmd_data),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_core(rd_core),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_core(wr_core), .wr_data(wr_data)
  );

  // target memory model
  logic [31:0] mem [256];
  logic        stall = 1'b0;
  logic [7:0]  tick = '0;
  logic        pre_en = 1'b0;
  logic [7:0]  pre_idx = '0;
  logic [31:0] pre_val = '0;
  int          n_rd = 0, n_wr = 0;
  logic [15:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [9:0]  last_rd_core = '0, last_wr_core = '0;

  assign rd_ready = !stall || tick[1:0] == 2'b11;
  assign wr_ready = !stall || tick[1:0] == 2'b01;

  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (pre_en) mem[pre_idx] <= pre_val;
    if (rd_valid && rd_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_addr[9:2]];
      n_rd         <= n_rd + 1;
      last_rd_addr <= rd_addr;
      last_rd_core <= rd_core;
    end else begin
      rd_rsp_valid <= 1'b0;
    end
    if (wr_valid && wr_ready) begin
      mem[wr_addr[9:2]] <= wr_data;
      n_wr         <= n_wr + 1;
      last_wr_addr <= wr_addr;
      last_wr_core <= wr_core;
    end
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v);
    int  r0, w0;
    logic got_err;
    @(negedge clk);
    pre_en = 1'b1; pre_idx = v.waddr[9:2]; pre_val = v.pre;
    @(negedge clk);
    pre_en = 1'b0;
    r0 = n_rd; w0 = n_wr;
    cmd_valid = 1'b1; cmd_addr = v.ofs; cmd_wide = v.wide; cmd_data = v.cmd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R8 busy after accept", {62'd0, busy, cmd_ready}, 64'd2);
    while (!rsp_valid) @(negedge clk);
    got_err = rsp_err;
    @(negedge clk);
    chk(!busy && cmd_ready, "R8 busy drops after response", {62'd0, busy, cmd_ready}, 64'd1);
    chk(got_err == v.err, "R1 R2 response error flag", 64'(got_err), 64'(v.err));
    chk((n_rd - r0) == int'(v.rd), "R5 R6 R2 read count", 64'(n_rd - r0), 64'(v.rd));
    chk((n_wr - w0) == int'(v.wr), "R1 R2 write count", 64'(n_wr - w0), 64'(v.wr));
    chk(mem[v.waddr[9:2]] == v.word, "R5 R6 R1 target word", 64'(mem[v.waddr[9:2]]), 64'(v.word));
    if (v.wr) begin
      chk(last_wr_addr == v.waddr, "R3 R4 write address", 64'(last_wr_addr), 64'(v.waddr));
      chk(last_wr_core == v.core, "R7 write identity", 64'(last_wr_core), 64'(v.core));
    end
    if (v.rd) begin
      chk(last_rd_addr == v.waddr, "R3 R4 read address", 64'(last_rd_addr), 64'(v.waddr));
      chk(last_rd_core == v.core, "R7 read identity", 64'(last_rd_core), 64'(v.core));
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R10: reset state, checked during and after reset
    chk(!busy && cmd_ready && !rd_valid && !wr_valid && !rsp_valid, "R10 reset state",
        {59'd0, busy, cmd_ready, rd_valid, wr_valid, rsp_valid}, 64'd8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && cmd_ready && !rd_valid && !wr_valid && !rsp_valid, "R10 idle after reset",
        {59'd0, busy, cmd_ready, rd_valid, wr_valid, rsp_valid}, 64'd8);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9: back-pressure on both request channels
    stall = 1'b1;
    run_vec(VECS[1]);
    run_vec(VECS[3]);
    run_vec(VECS[0]);
    stall = 1'b0;

    // R8: command raised while busy is not taken before the first completes
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 16'h0048; cmd_wide = 1'b1; cmd_data = 64'h0A0B0C0D_00000004;
    @(negedge clk);
    chk(busy && !cmd_ready, "R8 second command held off", {62'd0, busy, cmd_ready}, 64'd2);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready, "R8 ready again after response", 64'(cmd_ready), 64'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule